// File: doc/BRIEF.md
# Shared Mailbox Interrupt Controller

This block holds a small array of single-entry message mailboxes that two agents use to pass 32-bit words. Each mailbox is one register. Its most significant bit marks the entry as occupied, and its lower 31 bits carry the payload. A sender posts a message by writing the payload with the top bit set. A receiver drains the entry by writing zero to the whole register.

Every mailbox is either occupied or vacant, and it reports that state continuously. The occupied and vacant conditions of all mailboxes are packed into one status word. Each mailbox may gate its own two contributions with local enables. Several shared interrupt lines each apply their own enable mask to that status word. A line stays high as long as any enabled status bit is set.

A read-only capability word reports how many units of each kind the block exposes. All access goes through a simple synchronous register bus. A write takes effect at the clock edge where it is presented. Read data appears on the cycle after the address.

Top module: `shmbox_irq_ctrl`

## Requirements
- R1: After reset, every mailbox register, every per-mailbox enable and every line enable reads zero, and all interrupt lines are low.
- R2: Mailbox n has its data register at address 0x1000 + 0x10·n. A write stores all 32 bits, and the same value reads back. Bit 31 of the stored word is the occupied flag, and bits 30:0 are payload.
- R3: Writing zero to a mailbox data register clears every bit. It then reads zero and counts as vacant.
- R4: The status word is read at 0x304. Bit n (for bits 7:0) is 1 when mailbox n is vacant and its vacant-enable is 1. Bit 8+n (for bits 15:8) is 1 when mailbox n is occupied and its occupied-enable is 1. Bits 31:16 read zero.
- R5: The per-mailbox occupied-enable is at mailbox base + 0x4, and the vacant-enable is at base + 0x8. Only bit 0 of each is stored, and that bit is read back at bit 0 with zeros above.
- R6: Status bits follow the live mailbox state and are not sticky. A vacant, enabled mailbox keeps its bit set for as long as it stays vacant. A write to 0x304 changes nothing.
- R7: Line n has its enable register at 0x100 + 4·n. Bits 15:0 are stored, and bits 31:16 read zero. Line n is high exactly when (status AND enable n) is non-zero, in the same cycle the state changes.
- R8: The capability word is at 0x380 and ignores writes. It holds 4-bit counts: mailboxes in bits 3:0, shared semaphores in 7:4, arbitrated semaphores in 11:8, doorbells in 15:12 and interrupt lines in 19:16.
- R9: Read data for an address presented in one cycle is valid after the next rising edge. An unmapped address reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq_o | output | NUM_OUT | Level-sensitive shared interrupt lines |

## Verification
The bench targets several corner cases, each tied to a specific design error:
- Draining a mailbox whose payload is non-zero must clear every bit. A design that cleared only the flag would read back a stale payload.
- A vacant mailbox with its enables set must hold its line high over many cycles. A design that treated vacancy as an edge event would drop the line after one cycle.
- Writes to the status word, the capability word and an unmapped hole inside a mailbox's address window must leave all state as it was. A design with loose address decode would corrupt a neighbouring register there.
- Random traffic checks the packed status layout and every line against a bench model. A swapped half of the status word, or a mask applied to the wrong line, shows up as a mismatched interrupt.

// File: rtl/shmbox_pkg.sv
package shmbox_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int MAX_MBOX = 8;

  localparam logic [ADDR_W-1:0] LINE_EN_BASE = 16'h0100;
  localparam logic [ADDR_W-1:0] STATUS_ADDR  = 16'h0304;
  localparam logic [ADDR_W-1:0] CAPS_ADDR    = 16'h0380;
  localparam logic [ADDR_W-1:0] MBOX_BASE    = 16'h1000;
  localparam logic [ADDR_W-1:0] MBOX_STRIDE  = 16'h0010;
  localparam logic [ADDR_W-1:0] OCC_IE_OFS   = 16'h0004;
  localparam logic [ADDR_W-1:0] VAC_IE_OFS   = 16'h0008;

  typedef struct packed {
    logic [15:0]         rsvd;
    logic [MAX_MBOX-1:0] occupied;
    logic [MAX_MBOX-1:0] vacant;
  } status_t;
endpackage

// File: rtl/shmbox_slot.sv
module shmbox_slot
  import shmbox_pkg::*;
#(
  parameter int PER_IE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_box,
  input  logic              wr_occ_ie,
  input  logic              wr_vac_ie,
  output logic [DATA_W-1:0] box_q,
  output logic              occ_o,
  output logic              occ_ie_q,
  output logic              vac_ie_q
);
  logic [DATA_W-1:0] box_d;

  always_comb begin
    box_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      box_q <= '0;
    else if (wr_box) box_q <= box_d;
  end

  assign occ_o = box_q[DATA_W-1];

  generate
    if (PER_IE != 0) begin : g_ie
      logic occ_ie_d, vac_ie_d;
      always_comb begin
        occ_ie_d = wr_data[0];
        vac_ie_d = wr_data[0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ_ie_q <= 1'b0;
          vac_ie_q <= 1'b0;
        end else begin
          if (wr_occ_ie) occ_ie_q <= occ_ie_d;
          if (wr_vac_ie) vac_ie_q <= vac_ie_d;
        end
      end
    end else begin : g_no_ie
      assign occ_ie_q = 1'b1;
      assign vac_ie_q = 1'b1;
    end
  endgenerate

  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_box && wr_data == '0) |=> (box_q == '0 && !occ_o)); // R3
  AST_POST_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_box && wr_data[DATA_W-1]) |=> occ_o); // R2
endmodule

// File: rtl/shmbox_status.sv
module shmbox_status
  import shmbox_pkg::*;
#(
  parameter int NUM_MBOX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MBOX-1:0] occ,
  input  logic [NUM_MBOX-1:0] occ_ie,
  input  logic [NUM_MBOX-1:0] vac_ie,
  output logic [DATA_W-1:0]   status
);
  status_t st;

  generate
    for (genvar i = 0; i < MAX_MBOX; i++) begin : g_bit
      if (i < NUM_MBOX) begin : g_live
        assign st.occupied[i] = occ[i] & occ_ie[i];
        assign st.vacant[i]   = ~occ[i] & vac_ie[i];
      end else begin : g_pad
        assign st.occupied[i] = 1'b0;
        assign st.vacant[i]   = 1'b0;
      end
    end
  endgenerate

  assign st.rsvd = '0;
  assign status  = st;

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:0] & status[15:8]) == 8'h00); // R4
endmodule

// File: rtl/shmbox_irq_out.sv
module shmbox_irq_out (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic [15:0] status,
  output logic [15:0] en_q,
  output logic        irq
);
  logic [15:0] en_d;

  always_comb begin
    en_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  assign irq = |(status & en_q);

  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 16'h0000) |=> !irq); // R7
endmodule

// File: rtl/shmbox_irq_ctrl.sv
module shmbox_irq_ctrl
  import shmbox_pkg::*;
#(
  parameter int NUM_MBOX    = 8,
  parameter int NUM_OUT     = 4,
  parameter int PER_MBOX_IE = 1,
  parameter int NUM_SS      = 4,
  parameter int NUM_AS      = 8,
  parameter int NUM_DB      = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_OUT-1:0] irq_o
);
  localparam logic [DATA_W-1:0] CAPS_WORD = {12'h000, 4'(NUM_OUT), 4'(NUM_DB),
                                             4'(NUM_AS), 4'(NUM_SS), 4'(NUM_MBOX)};

  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic [DATA_W-1:0]   box_q [NUM_MBOX];
  logic [NUM_MBOX-1:0] occ, occ_ie, vac_ie;
  logic [NUM_MBOX-1:0] sel_box, sel_occ_ie, sel_vac_ie;
  logic [NUM_OUT-1:0]  sel_en;
  logic [15:0]         en_q [NUM_OUT];
  logic [DATA_W-1:0]   status;
  logic [DATA_W-1:0]   rdata_d;

  generate
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] BASE = MBOX_BASE + ADDR_W'(i) * MBOX_STRIDE;
      assign sel_box[i]    = (bus_addr == BASE);
      assign sel_occ_ie[i] = (bus_addr == BASE + OCC_IE_OFS);
      assign sel_vac_ie[i] = (bus_addr == BASE + VAC_IE_OFS);

      shmbox_slot #(.PER_IE(PER_MBOX_IE)) u_slot (
        .clk       (clk),
        .rst_n     (srst_n),
        .wr_data   (bus_wdata),
        .wr_box    (bus_wr & sel_box[i]),
        .wr_occ_ie (bus_wr & sel_occ_ie[i]),
        .wr_vac_ie (bus_wr & sel_vac_ie[i]),
        .box_q     (box_q[i]),
        .occ_o     (occ[i]),
        .occ_ie_q  (occ_ie[i]),
        .vac_ie_q  (vac_ie[i])
      );
    end
  endgenerate

  shmbox_status #(.NUM_MBOX(NUM_MBOX)) u_status (
    .clk    (clk),
    .rst_n  (srst_n),
    .occ    (occ),
    .occ_ie (occ_ie),
    .vac_ie (vac_ie),
    .status (status)
  );

  generate
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_line
      assign sel_en[j] = (bus_addr == LINE_EN_BASE + ADDR_W'(4 * j));

      shmbox_irq_out u_line (
        .clk     (clk),
        .rst_n   (srst_n),
        .wr_en   (bus_wr & sel_en[j]),
        .wr_data (bus_wdata[15:0]),
        .status  (status[15:0]),
        .en_q    (en_q[j]),
        .irq     (irq_o[j])
      );
    end
  endgenerate

  always_comb begin
    rdata_d = '0;
    if (bus_addr == STATUS_ADDR) rdata_d = status;
    if (bus_addr == CAPS_ADDR)   rdata_d = CAPS_WORD;
    for (int j = 0; j < NUM_OUT; j++) begin
      if (sel_en[j]) rdata_d = {16'h0000, en_q[j]};
    end
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (sel_box[i]) rdata_d = box_q[i];
      if (sel_occ_ie[i] && PER_MBOX_IE != 0) rdata_d = {31'd0, occ_ie[i]};
      if (sel_vac_ie[i] && PER_MBOX_IE != 0) rdata_d = {31'd0, vac_ie[i]};
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) bus_rdata <= '0;
    else         bus_rdata <= rdata_d;
  end

  AST_CAPS_FIXED: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr == CAPS_ADDR && !bus_wr) |=> (bus_rdata == CAPS_WORD)); // R8
endmodule

// File: tb/shmbox_irq_ctrl_bench.sv
module shmbox_irq_ctrl_bench;
  localparam int NMB  = 8;
  localparam int NOUT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NOUT-1:0] irq_o;

  always #10 clk = ~clk;

  shmbox_irq_ctrl u_shmbox_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_box [NMB];
  logic        m_occ_ie [NMB];
  logic        m_vac_ie [NMB];
  logic [15:0] m_en [NOUT];

  function automatic logic [15:0] box_addr(int i);
    return 16'h1000 + 16'(16 * i);
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    for (int i = 0; i < NMB; i++) begin
      s[i]     = !m_box[i][31] && m_vac_ie[i];
      s[8 + i] =  m_box[i][31] && m_occ_ie[i];
    end
    return s;
  endfunction

  function automatic logic [NOUT-1:0] exp_irq();
    logic [NOUT-1:0] v;
    logic [31:0] s = exp_status();
    for (int j = 0; j < NOUT; j++) v[j] = |(s[15:0] & m_en[j]);
    return v;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input logic [15:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    check(bus_rdata, exp, req);
  endtask

  task automatic irq_check(input string req);
    check(32'(irq_o), 32'(exp_irq()), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NMB; i++) begin
      m_box[i] = '0; m_occ_ie[i] = 1'b0; m_vac_ie[i] = 1'b0;
    end
    for (int j = 0; j < NOUT; j++) m_en[j] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < NMB; i++) begin
      read_check(box_addr(i), 32'h0, "R1 box");
      read_check(box_addr(i) + 16'h4, 32'h0, "R1 occ_ie");
      read_check(box_addr(i) + 16'h8, 32'h0, "R1 vac_ie");
    end
    for (int j = 0; j < NOUT; j++) read_check(16'h0100 + 16'(4 * j), 32'h0, "R1 line enable");
    check(32'(irq_o), 32'h0, "R1 lines low");

    // R8: capability word, writes ignored
    read_check(16'h0380, 32'h00049848, "R8 caps");
    bus_write(16'h0380, 32'hFFFF_FFFF);
    read_check(16'h0380, 32'h00049848, "R8 caps after write");

    // R7: enable upper bits not stored
    bus_write(16'h0100, 32'hFFFF_FFFF); m_en[0] = 16'hFFFF;
    read_check(16'h0100, 32'h0000_FFFF, "R7 enable width");
    irq_check("R7 all masked in, status zero");

    // R5 / R6: vacant mailbox holds its line high (level)
    bus_write(box_addr(2) + 16'h8, 32'hFFFF_FFFF); m_vac_ie[2] = 1'b1;
    read_check(box_addr(2) + 16'h8, 32'h1, "R5 vac_ie bit0 only");
    irq_check("R6 vacant raises line");
    check(32'(irq_o[0]), 32'h1, "R6 line0 high");
    repeat (20) @(negedge clk);
    check(32'(irq_o[0]), 32'h1, "R6 level held while vacant");
    read_check(16'h0304, 32'h0000_0004, "R4 vacant bit 2");

    // R6: status write has no effect
    bus_write(16'h0304, 32'h0000_0000);
    read_check(16'h0304, 32'h0000_0004, "R6 status write ignored");

    // R2 / R3: post then drain with payload
    bus_write(box_addr(2), 32'hDEAD_BEEF); m_box[2] = 32'hDEAD_BEEF;
    read_check(box_addr(2), 32'hDEAD_BEEF, "R2 readback");
    irq_check("R6 vacant bit cleared on post");
    bus_write(box_addr(2) + 16'h4, 32'h1); m_occ_ie[2] = 1'b1;
    read_check(16'h0304, 32'h0000_0400, "R4 occupied bit 10");
    bus_write(box_addr(2), 32'h0); m_box[2] = 32'h0;
    read_check(box_addr(2), 32'h0, "R3 drain clears all");
    read_check(16'h0304, 32'h0000_0004, "R3 vacant again");

    // R9: unmapped hole in mailbox window, unmapped far address
    bus_write(box_addr(3) + 16'hC, 32'hFFFF_FFFF);
    bus_write(16'h2000, 32'hFFFF_FFFF);
    read_check(box_addr(3) + 16'hC, 32'h0, "R9 hole reads zero");
    read_check(16'h2000, 32'h0, "R9 unmapped reads zero");
    for (int i = 0; i < NMB; i++) read_check(box_addr(i), m_box[i], "R9 no stray write");
    read_check(16'h0304, exp_status(), "R9 status unchanged");

    // R7: disabling the mask drops the line
    bus_write(16'h0100, 32'h0); m_en[0] = '0;
    check(32'(irq_o[0]), 32'h0, "R7 mask off drops line");

    // Random traffic
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 7);
      int i  = $urandom_range(0, NMB - 1);
      int j  = $urandom_range(0, NOUT - 1);
      logic [31:0] d = $urandom();
      case (op)
        0, 1: begin d[31] = 1'b1; bus_write(box_addr(i), d); m_box[i] = d; end
        2:    begin bus_write(box_addr(i), 32'h0); m_box[i] = '0; end
        3:    begin d[31] = 1'b0; bus_write(box_addr(i), d); m_box[i] = d; end
        4:    begin
                if (d[4]) begin bus_write(box_addr(i) + 16'h4, d); m_occ_ie[i] = d[0]; end
                else      begin bus_write(box_addr(i) + 16'h8, d); m_vac_ie[i] = d[0]; end
              end
        5:    begin bus_write(16'h0100 + 16'(4 * j), d); m_en[j] = d[15:0]; end
        6:    read_check(box_addr(i), m_box[i], "R2 random readback");
        default: read_check(16'h0304, exp_status(), "R4 random status");
      endcase
      irq_check("R7 random lines");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule